// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits in the data path of an SDRAM controller after a row has been opened. When the controller issues a read or write command with a start column, the sequencer produces one column address per clock for every beat of the burst. The burst length and the ordering (linear or interleaved) are taken from the mode settings present on the command cycle. For writes it produces a per-beat write enable that DQM gates in the same cycle. For reads it produces a data-valid strobe delayed by the CAS latency. DQM blanks that strobe two cycles after it is sampled. The block also produces a high-impedance control for the data bus.

Column addresses wrap inside the aligned block the size of the burst, so every burst moves exactly its programmed number of beats wherever it starts. A full-page length wraps at the row end and continues until something ends it. A new command replaces the running burst in the cycle it arrives, and back-to-back reads leave no gap on the bus. A stop input (burst stop or precharge) drops the remaining beats. Read beats already issued still come out after the CAS latency.

Top module: `sdr_burst_seq`

## Requirements
- R1: On a command cycle (`cmd_valid`=1) a beat is issued in that same cycle: `beat_valid`=1, `beat_col`=`cmd_col`, `beat_write`=`cmd_write`. A command has priority over `cmd_stop` in the same cycle.
- R2: `bl_sel` codes 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. With `burst_ilv`=0, beat i of a burst starting at column S with length L is at column (S − S mod L) + ((S mod L + i) mod L).
- R3: With `burst_ilv`=1 and a length of 2, 4 or 8, beat i is at column (S − S mod L) + ((S mod L) XOR i).
- R4: `bl_sel`=7 selects full page. Beat i is at column (S + i) mod 2^COL_W, `burst_ilv` is ignored, and beats continue until a new command or a stop.
- R5: A burst that is not full page issues exactly L beats on consecutive cycles. `beat_valid` is then low until the next command.
- R6: `wr_en` is 1 exactly when the current beat is a write beat and `dqm` is 0 in that cycle.
- R7: A read beat issued in cycle t makes `rd_beat` high in cycle t+CL. CL is `cas_lat` (1 to 3), and a `cas_lat` of 0 is treated as 1.
- R8: `rd_valid` equals `rd_beat` AND NOT (`dqm` sampled two cycles earlier). `dq_hiz` is 1 whenever `rd_valid` is 0.
- R9: A command arriving during a burst ends it immediately and starts the new burst in the same cycle. A read issued in the cycle after the last read beat gives a gapless `rd_valid` run.
- R10: `cmd_stop` without a command suppresses the beat in its cycle and all later beats of the burst. Read beats issued before the stop still reach `rd_beat`.
- R11: After synchronous reset no beat is active, `rd_beat`/`rd_valid` are 0 and `dq_hiz` is 1.
- R12: Burst length and type are captured on the command cycle. Changes on `bl_sel`/`burst_ilv` during a burst do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Read or write command this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_col | input | COL_W | Start column of the command |
| cmd_stop | input | 1 | Burst stop or precharge: end the running burst |
| bl_sel | input | 3 | Burst length code (0..3 = 1,2,4,8; 7 = full page) |
| burst_ilv | input | 1 | 1 = interleaved ordering |
| cas_lat | input | CLW | CAS latency in cycles |
| dqm | input | 1 | Data mask |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_write | output | 1 | Current beat belongs to a write |
| beat_col | output | COL_W | Column address of the current beat |
| wr_en | output | 1 | Write data accepted this cycle |
| rd_beat | output | 1 | A read data beat is due on the bus this cycle |
| rd_valid | output | 1 | Read data beat present and not masked |
| dq_hiz | output | 1 | Data bus high impedance |

## Verification
Directed cases check literal address sequences: a linear length-4 burst starting mid-block, which must wrap back to the block base, and an interleaved length-8 burst from an odd column, which separates XOR ordering from addition. A full-page burst crosses the row end and is then stopped. This checks that wrapping uses the column width and not the burst length, and that read beats in flight still drain. A long random phase mixes commands, stops, DQM and mode changes in the middle of bursts, with CAS latency varied between segments. It compares every output in every cycle against a bench model. That model separates replacement of a running burst from its completion, and the read mask delay from the write mask delay.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        BL_ONE  = 3'd0,
        BL_TWO  = 3'd1,
        BL_FOUR = 3'd2,
        BL_EGT  = 3'd3,
        BL_PAGE = 3'd7
    } bl_code_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } beat_dir_e;

    // log2 of the burst length; reserved codes behave as a single beat
    function automatic logic [1:0] bl_log2(input logic [2:0] code);
        case (code)
            BL_TWO:  return 2'd1;
            BL_FOUR: return 2'd2;
            BL_EGT:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic bl_is_page(input logic [2:0] code);
        return code == BL_PAGE;
    endfunction

endpackage

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
    import sbs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [2:0]       bl_sel,
    input  logic             burst_ilv,
    output logic             beat_valid,
    output logic             beat_write,
    output logic [COL_W-1:0] beat_col
);

    typedef struct packed {
        logic             act;
        beat_dir_e        dir;
        logic             page;
        logic             ilv;
        logic [1:0]       lg;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] idx;
    } burst_t;

    burst_t cur, nxt;

    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] offs;
    logic [COL_W-1:0] cont_col;

    always_comb begin
        blk_mask = cur.page ? {COL_W{1'b1}} : COL_W'((1 << cur.lg) - 1);
        offs     = (cur.ilv && !cur.page) ? (cur.start ^ cur.idx)
                                          : (cur.start + cur.idx);
        cont_col = (cur.start & ~blk_mask) | (offs & blk_mask);
    end

    always_comb begin
        beat_valid = 1'b0;
        beat_write = 1'b0;
        beat_col   = '0;
        if (cmd_valid) begin
            beat_valid = 1'b1;
            beat_write = cmd_write;
            beat_col   = cmd_col;
        end else if (!cmd_stop && cur.act) begin
            beat_valid = 1'b1;
            beat_write = (cur.dir == DIR_WR);
            beat_col   = cont_col;
        end
    end

    always_comb begin
        nxt = cur;
        if (cmd_valid) begin
            nxt.dir   = cmd_write ? DIR_WR : DIR_RD;
            nxt.page  = bl_is_page(bl_sel);
            nxt.ilv   = burst_ilv;
            nxt.lg    = bl_log2(bl_sel);
            nxt.start = cmd_col;
            nxt.idx   = COL_W'(1);
            nxt.act   = bl_is_page(bl_sel) || (bl_log2(bl_sel) != 2'd0);
        end else if (cmd_stop) begin
            nxt.act = 1'b0;
        end else if (cur.act) begin
            nxt.idx = cur.idx + COL_W'(1);
            if (!cur.page && cur.idx == blk_mask) begin
                nxt.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
    parameter int CL_MAX = 3,
    localparam int CLW   = $clog2(CL_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_issue,
    input  logic           dqm,
    input  logic [CLW-1:0] cas_lat,
    output logic           rd_beat,
    output logic           rd_valid
);

    localparam int MASK_DLY = 2;

    logic [CL_MAX:0]   stage;
    logic [MASK_DLY:0] mstage;
    logic [CLW-1:0]    cl_eff;

    assign stage[0]  = rd_issue;
    assign mstage[0] = dqm;

    for (genvar k = 1; k <= CL_MAX; k++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) stage[k] <= 1'b0;
            else     stage[k] <= stage[k-1];
        end
    end

    for (genvar k = 1; k <= MASK_DLY; k++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) mstage[k] <= 1'b0;
            else     mstage[k] <= mstage[k-1];
        end
    end

    always_comb begin
        if (cas_lat == '0)                   cl_eff = CLW'(1);
        else if (int'(cas_lat) > CL_MAX)     cl_eff = CLW'(CL_MAX);
        else                                 cl_eff = cas_lat;
    end

    assign rd_beat  = stage[cl_eff];
    assign rd_valid = rd_beat && !mstage[MASK_DLY];

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
    parameter int COL_W  = 9,
    parameter int CL_MAX = 3,
    localparam int CLW   = $clog2(CL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [2:0]       bl_sel,
    input  logic             burst_ilv,
    input  logic [CLW-1:0]   cas_lat,
    input  logic             dqm,
    output logic             beat_valid,
    output logic             beat_write,
    output logic [COL_W-1:0] beat_col,
    output logic             wr_en,
    output logic             rd_beat,
    output logic             rd_valid,
    output logic             dq_hiz
);

    sbs_col_gen #(.COL_W(COL_W)) u_col (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_col    (cmd_col),
        .cmd_stop   (cmd_stop),
        .bl_sel     (bl_sel),
        .burst_ilv  (burst_ilv),
        .beat_valid (beat_valid),
        .beat_write (beat_write),
        .beat_col   (beat_col)
    );

    sbs_rd_pipe #(.CL_MAX(CL_MAX)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (beat_valid && !beat_write),
        .dqm      (dqm),
        .cas_lat  (cas_lat),
        .rd_beat  (rd_beat),
        .rd_valid (rd_valid)
    );

    // write mask acts in the cycle it is sampled
    assign wr_en  = beat_valid && beat_write && !dqm;
    assign dq_hiz = !rd_valid;

endmodule

// File: rtl/sbs_checks.sv
module sbs_checks #(
    parameter int COL_W = 9,
    parameter int CLW   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_write,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic             dqm,
    input logic [CLW-1:0]   cas_lat,
    input logic             beat_valid,
    input logic             beat_write,
    input logic [COL_W-1:0] beat_col,
    input logic             wr_en,
    input logic             rd_beat,
    input logic             rd_valid
);

    a_r1_cmd_beat: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (beat_valid && beat_col == cmd_col && beat_write == cmd_write));

    a_r10_stop_blocks: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop && !cmd_valid) |-> !beat_valid);

    a_r6_wr_gate: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (beat_valid && beat_write && !dqm));

    a_r8_rd_mask: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_beat && !$past(dqm, 2)));

    a_r7_cl2_origin: assert property (@(posedge clk) disable iff (rst)
        (rd_beat && cas_lat == CLW'(2)) |-> $past(beat_valid && !beat_write, 2));

    a_r5_no_orphan_beat: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !cmd_valid) |-> $past(beat_valid));

endmodule

bind sdr_burst_seq sbs_checks #(.COL_W(COL_W), .CLW(CLW)) u_sbs_checks (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_col    (cmd_col),
    .cmd_stop   (cmd_stop),
    .dqm        (dqm),
    .cas_lat    (cas_lat),
    .beat_valid (beat_valid),
    .beat_write (beat_write),
    .beat_col   (beat_col),
    .wr_en      (wr_en),
    .rd_beat    (rd_beat),
    .rd_valid   (rd_valid)
);

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;

    localparam int COL_W = 9;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_stop = 1'b0;
    logic [2:0]       bl_sel = 3'd0;
    logic             burst_ilv = 1'b0;
    logic [1:0]       cas_lat = 2'd2;
    logic             dqm = 1'b0;
    logic             beat_valid, beat_write, wr_en, rd_beat, rd_valid, dq_hiz;
    logic [COL_W-1:0] beat_col;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    bit m_act, m_wr, m_page, m_ilv;
    int m_start, m_len, m_idx;
    bit rdq [8];
    bit dqq [8];
    int ncyc;

    always #10 clk = ~clk;

    sdr_burst_seq #(.COL_W(COL_W), .CL_MAX(3)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_stop(cmd_stop), .bl_sel(bl_sel),
        .burst_ilv(burst_ilv), .cas_lat(cas_lat), .dqm(dqm),
        .beat_valid(beat_valid), .beat_write(beat_write), .beat_col(beat_col),
        .wr_en(wr_en), .rd_beat(rd_beat), .rd_valid(rd_valid), .dq_hiz(dq_hiz)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_col(int s, int len, int i, bit page, bit ilv);
        int base, off;
        if (page) return (s + i) % ROW;
        base = s - (s % len);
        off  = s % len;
        if (ilv) return base + (off ^ i);
        return base + ((off + i) % len);
    endfunction

    function automatic int len_of(logic [2:0] c);
        return (c == 3'd7) ? 0 : (1 << c);
    endfunction

    task automatic model_reset();
        m_act = 0; ncyc = 0;
        for (int k = 0; k < 8; k++) begin rdq[k] = 0; dqq[k] = 0; end
    endtask

    // called mid-cycle, inputs settled
    task automatic check_cycle(output int seen);
        bit ev, ew, erd, erv;
        int ec, cl;
        string ctag;
        ev = 0; ew = 0; ec = 0; ctag = "R2";
        if (cmd_valid) begin
            ev = 1; ew = cmd_write; ec = int'(cmd_col); ctag = "R1";
            m_start = int'(cmd_col); m_wr = cmd_write;
            m_page = (bl_sel == 3'd7); m_ilv = burst_ilv;   // R12 captured here
            m_len = len_of(bl_sel); m_idx = 1;
            m_act = m_page || (m_len > 1);
        end else if (cmd_stop) begin
            m_act = 0;                                       // R10
        end else if (m_act) begin
            ev = 1; ew = m_wr;
            ec = model_col(m_start, m_len, m_idx, m_page, m_ilv);
            ctag = m_page ? "R4" : (m_ilv ? "R3" : "R2");
            m_idx++;
            if (!m_page && m_idx == m_len) m_act = 0;        // R5
        end
        cl  = (cas_lat == 0) ? 1 : int'(cas_lat);
        erd = rdq[(ncyc - cl) & 7];
        erv = erd && !dqq[(ncyc - 2) & 7];
        chk(beat_valid == ev, "R5 R9 R10 beat_valid", beat_valid, ev);
        if (ev) begin
            chk(int'(beat_col) == ec, {ctag, " beat_col"}, beat_col, ec);
            chk(beat_write == ew, "R1 beat_write", beat_write, ew);
        end
        chk(wr_en == (ev && ew && !dqm), "R6 wr_en", wr_en, ev && ew && !dqm);
        chk(rd_beat == erd, "R7 rd_beat", rd_beat, erd);
        chk(rd_valid == erv, "R8 rd_valid", rd_valid, erv);
        chk(dq_hiz == !erv, "R8 dq_hiz", dq_hiz, !erv);
        rdq[ncyc & 7] = ev && !ew;
        dqq[ncyc & 7] = dqm;
        ncyc++;
        seen = int'(beat_col);
    endtask

    task automatic step(input bit cv, input bit cw, input int col, input logic [2:0] bl,
                        input bit il, input bit st, input bit dm, output int seen);
        cmd_valid = cv; cmd_write = cw; cmd_col = COL_W'(col);
        bl_sel = bl; burst_ilv = il; cmd_stop = st; dqm = dm;
        #5;
        check_cycle(seen);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        int s;
        for (int k = 0; k < n; k++) step(0, 0, 0, bl_sel, burst_ilv, 0, 0, s);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int s;
        int exp4 [4];
        int exp8 [8];
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(beat_valid == 0, "R11 beat_valid", beat_valid, 0);
        chk(rd_valid == 0, "R11 rd_valid", rd_valid, 0);
        chk(dq_hiz == 1, "R11 dq_hiz", dq_hiz, 1);
        rst = 0;
        @(negedge clk);

        // R2: linear length 4 from column 6 wraps to 4
        exp4 = '{6, 7, 4, 5};
        step(1, 1, 6, 3'd2, 0, 0, 0, s);
        chk(s == exp4[0], "R2 literal", s, exp4[0]);
        for (int k = 1; k < 4; k++) begin
            step(0, 0, 0, 3'd0, 1, 0, 0, s);     // R12: mode change mid-burst
            chk(s == exp4[k], "R2 R12 literal", s, exp4[k]);
        end
        idle(2);

        // R3: interleaved length 8 from column 13
        exp8 = '{13, 12, 15, 14, 9, 8, 11, 10};
        step(1, 0, 13, 3'd3, 1, 0, 0, s);
        chk(s == exp8[0], "R3 literal", s, exp8[0]);
        for (int k = 1; k < 8; k++) begin
            step(0, 0, 0, 3'd3, 1, 0, 0, s);
            chk(s == exp8[k], "R3 literal", s, exp8[k]);
        end
        idle(5);

        // R4 + R10: full page across the row end, stopped; reads drain
        cas_lat = 2'd3;
        step(1, 0, ROW - 2, 3'd7, 1, 0, 0, s);
        for (int k = 1; k < 6; k++) begin
            step(0, 0, 0, 3'd7, 1, 0, 0, s);
            chk(s == (ROW - 2 + k) % ROW, "R4 literal", s, (ROW - 2 + k) % ROW);
        end
        step(0, 0, 0, 3'd7, 0, 1, 0, s);
        idle(5);

        // R9: back-to-back length-2 reads, gapless; R7 with cas_lat 0
        cas_lat = 2'd0;
        step(1, 0, 20, 3'd1, 0, 0, 0, s);
        step(0, 0, 0, 3'd1, 0, 0, 0, s);
        step(1, 0, 40, 3'd1, 0, 0, 0, s);
        step(0, 0, 0, 3'd1, 0, 0, 1, s);        // R8 mask two cycles later
        idle(6);

        // random phase
        for (int seg = 0; seg < 12; seg++) begin
            cas_lat = 2'($urandom_range(0, 3));
            for (int k = 0; k < 250; k++) begin
                bit cv, st, dm, il, cw;
                logic [2:0] bl;
                int pick;
                cv   = ($urandom_range(0, 99) < 14);
                st   = ($urandom_range(0, 99) < 4);
                dm   = ($urandom_range(0, 99) < 20);
                il   = 1'($urandom_range(0, 1));
                cw   = 1'($urandom_range(0, 1));
                pick = $urandom_range(0, 4);
                bl   = (pick == 4) ? 3'd7 : 3'(pick);
                step(cv, cw, $urandom_range(0, ROW - 1), bl, il, st, dm, s);
            end
        end
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule